// File: doc/BRIEF.md
# VGA Planar Write Datapath

This block turns a single host byte, written into a legacy four-plane frame buffer, into a 32-bit word. The word holds one 8-bit lane per plane and goes out with a per-plane byte enable. A right-rotate stage conditions the host byte. One of four write modes then builds the raw plane data. Where the effective bit mask is clear, the result is merged against a 32-bit display latch.

The latch is filled from the frame buffer on every read access. This lets the latch feed screen-to-screen copies and keep pixels that a write must not disturb. Address decode, the memory array and bus handshakes sit outside the block.

The output word, the byte enables and a one-cycle valid strobe are registered. Results appear on the clock edge after the write is presented.

Top module: `vga_plane_wr_path`

## Requirements
- R1: In write modes 0 and 3, the host byte is first rotated right by `rot_cnt_i` positions (0 to 7). For this rotation, output bit i takes input bit (i + count) mod 8. The value loaded into the display latch is never rotated.
- R2: Write mode 0 (`wmode_i` = 0): plane b (bits 8b+7..8b of the word) takes the rotated host byte when `sr_en_i[b]` is 0. When `sr_en_i[b]` is 1, it takes `sr_val_i[b]` copied into all eight bits.
- R3: Write mode 1 (`wmode_i` = 1): the whole 32-bit result equals the display latch. The host byte, the rotate count, the set/reset inputs and `bmask_i` have no effect.
- R4: Write mode 2 (`wmode_i` = 2): plane b takes unrotated host bit b copied into all eight bits.
- R5: Write mode 3 (`wmode_i` = 3): plane b takes `sr_val_i[b]` copied into all eight bits. The effective mask is the rotated host byte ANDed with `bmask_i`.
- R6: In modes 0, 2 and 3, output bit 8b+n takes the computed bit when mask bit n is 1 and latch bit 8b+n when it is 0. In modes 0 and 2 the mask is `bmask_i`.
- R7: When `rd_load_i` is high at a clock edge, the latch takes all 32 bits of `rd_dword_i`. A write in that same cycle still merges against the latch value held before the load.
- R8: `wbe_o` equals the `plane_en_i` presented with the write, unchanged.
- R9: `wvalid_o` is high for exactly the cycle after each cycle with `wr_valid_i` high. When no write is presented, `wdata_o` and `wbe_o` hold their values.
- R10: After reset, `wdata_o`, `wbe_o`, `wvalid_o` and the display latch are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | A host write is presented this cycle |
| host_byte_i | input | 8 | Host write data |
| wmode_i | input | 2 | Write mode 0..3 |
| rot_cnt_i | input | 3 | Right-rotate amount |
| sr_val_i | input | 4 | Per-plane set/reset value |
| sr_en_i | input | 4 | Per-plane set/reset enable (mode 0) |
| bmask_i | input | 8 | Bit mask byte |
| plane_en_i | input | 4 | Plane write enables |
| rd_load_i | input | 1 | Frame-buffer read: load display latch |
| rd_dword_i | input | 32 | Frame-buffer word read |
| wdata_o | output | 32 | Merged write word |
| wbe_o | output | 4 | Plane byte enables |
| wvalid_o | output | 1 | Write result valid strobe |

## Verification
A latch load from a frame-buffer read and a host write can fall in the same cycle. The write must then merge against the old latch contents, while the new word becomes visible only to later writes. The bench provokes this with directed mode-1 writes issued alongside a load, followed by a second mode-1 write. The random phase also raises loads and writes independently in the same cycle. The bench's own latch model, updated only after the expected word is formed, judges every result.

// File: rtl/vga_wr_pkg.sv
package vga_wr_pkg;
   typedef enum logic [1:0] {
      WM_SETRST = 2'd0,
      WM_LATCH  = 2'd1,
      WM_COLOR  = 2'd2,
      WM_FILL   = 2'd3
   } wmode_e;
endpackage

// File: rtl/vga_wr_rotr.sv
module vga_wr_rotr #(
   parameter int W     = 8,
   parameter int STYLE = 0,
   localparam int RW   = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [RW-1:0] amt,
   output logic [W-1:0]  dout
);
   generate
      if (STYLE == 0) begin : g_mux
         always_comb begin
            for (int i = 0; i < W; i++) begin
               int j;
               j = i + int'(amt);
               if (j >= W) j = j - W;
               dout[i] = din[j];
            end
         end
      end else begin : g_dbl
         logic [2*W-1:0] dbl;
         always_comb dbl = {din, din} >> amt;
         assign dout = dbl[W-1:0];
      end
   endgenerate
endmodule

// File: rtl/vga_wr_plane_sel.sv
module vga_wr_plane_sel
   import vga_wr_pkg::*;
#(
   parameter int PLANES = 4,
   parameter int W      = 8,
   localparam int DW    = PLANES * W
) (
   input  wmode_e            mode,
   input  logic [W-1:0]      host_raw,
   input  logic [W-1:0]      host_rot,
   input  logic [PLANES-1:0] sr_val,
   input  logic [PLANES-1:0] sr_en,
   input  logic [W-1:0]      bmask,
   input  logic [DW-1:0]     latch,
   output logic [DW-1:0]     comp,
   output logic [W-1:0]      mask
);
   for (genvar b = 0; b < PLANES; b++) begin : g_plane
      always_comb begin
         unique case (mode)
            WM_SETRST: comp[b*W +: W] = sr_en[b] ? {W{sr_val[b]}} : host_rot;
            WM_LATCH:  comp[b*W +: W] = latch[b*W +: W];
            WM_COLOR:  comp[b*W +: W] = {W{host_raw[b]}};
            default:   comp[b*W +: W] = {W{sr_val[b]}};
         endcase
      end
   end

   always_comb begin
      unique case (mode)
         WM_LATCH: mask = '1;
         WM_FILL:  mask = host_rot & bmask;
         default:  mask = bmask;
      endcase
   end
endmodule

// File: rtl/vga_wr_merge.sv
module vga_wr_merge #(
   parameter int PLANES = 4,
   parameter int W      = 8,
   localparam int DW    = PLANES * W
) (
   input  logic [DW-1:0] comp,
   input  logic [DW-1:0] latch,
   input  logic [W-1:0]  mask,
   output logic [DW-1:0] merged
);
   for (genvar b = 0; b < PLANES; b++) begin : g_lane
      assign merged[b*W +: W] = (comp[b*W +: W] & mask) | (latch[b*W +: W] & ~mask);
   end
endmodule

// File: rtl/vga_plane_wr_path.sv
module vga_plane_wr_path
   import vga_wr_pkg::*;
#(
   parameter int PLANES    = 4,
   parameter int LANE_W    = 8,
   parameter int ROT_STYLE = 0,
   localparam int RW       = $clog2(LANE_W),
   localparam int DW       = PLANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid_i,
   input  logic [LANE_W-1:0] host_byte_i,
   input  logic [1:0]        wmode_i,
   input  logic [RW-1:0]     rot_cnt_i,
   input  logic [PLANES-1:0] sr_val_i,
   input  logic [PLANES-1:0] sr_en_i,
   input  logic [LANE_W-1:0] bmask_i,
   input  logic [PLANES-1:0] plane_en_i,
   input  logic              rd_load_i,
   input  logic [DW-1:0]     rd_dword_i,
   output logic [DW-1:0]     wdata_o,
   output logic [PLANES-1:0] wbe_o,
   output logic              wvalid_o
);
   if (LANE_W < 2 || (1 << RW) != LANE_W) begin : g_bad_lane
      $error("LANE_W must be a power of two of at least 2");
   end
   if (PLANES < 1 || PLANES > LANE_W) begin : g_bad_planes
      $error("PLANES must be between 1 and LANE_W");
   end
   if (ROT_STYLE != 0 && ROT_STYLE != 1) begin : g_bad_style
      $error("ROT_STYLE must be 0 or 1");
   end

   logic [DW-1:0]     latch_q;
   logic [LANE_W-1:0] host_rot;
   logic [DW-1:0]     comp;
   logic [LANE_W-1:0] mask;
   logic [DW-1:0]     merged;
   wmode_e            mode;

   assign mode = wmode_e'(wmode_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         latch_q <= '0;
      else if (rd_load_i) latch_q <= rd_dword_i;
   end

   vga_wr_rotr #(.W(LANE_W), .STYLE(ROT_STYLE)) u_rot (
      .din  (host_byte_i),
      .amt  (rot_cnt_i),
      .dout (host_rot)
   );

   vga_wr_plane_sel #(.PLANES(PLANES), .W(LANE_W)) u_sel (
      .mode     (mode),
      .host_raw (host_byte_i),
      .host_rot (host_rot),
      .sr_val   (sr_val_i),
      .sr_en    (sr_en_i),
      .bmask    (bmask_i),
      .latch    (latch_q),
      .comp     (comp),
      .mask     (mask)
   );

   vga_wr_merge #(.PLANES(PLANES), .W(LANE_W)) u_mrg (
      .comp   (comp),
      .latch  (latch_q),
      .mask   (mask),
      .merged (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdata_o  <= '0;
         wbe_o    <= '0;
         wvalid_o <= 1'b0;
      end else begin
         wvalid_o <= wr_valid_i;
         if (wr_valid_i) begin
            wdata_o <= merged;
            wbe_o   <= plane_en_i;
         end
      end
   end
endmodule

// File: rtl/vga_plane_wr_path_chk.sv
module vga_plane_wr_path_chk #(
   parameter int PLANES = 4,
   parameter int LANE_W = 8,
   localparam int DW    = PLANES * LANE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid_i,
   input logic [LANE_W-1:0] host_byte_i,
   input logic [1:0]        wmode_i,
   input logic [LANE_W-1:0] bmask_i,
   input logic [PLANES-1:0] plane_en_i,
   input logic              rd_load_i,
   input logic [DW-1:0]     rd_dword_i,
   input logic [DW-1:0]     latch_q,
   input logic [DW-1:0]     wdata_o,
   input logic [PLANES-1:0] wbe_o,
   input logic              wvalid_o
);
   p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_i |=> wvalid_o);
   p_valid_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid_i |=> !wvalid_o);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid_i |=> ($stable(wdata_o) && $stable(wbe_o)));
   p_be_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_i |=> (wbe_o == $past(plane_en_i)));
   p_latch_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_load_i |=> (latch_q == $past(rd_dword_i)));
   p_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_i && wmode_i == 2'd1) |=> (wdata_o == $past(latch_q)));
   p_zero_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_i && (wmode_i == 2'd0 || wmode_i == 2'd2) && bmask_i == '0)
      |=> (wdata_o == $past(latch_q)));

   for (genvar b = 0; b < PLANES; b++) begin : g_color
      p_color_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_valid_i && wmode_i == 2'd2 && bmask_i == '1)
         |=> (wdata_o[b*LANE_W +: LANE_W] == {LANE_W{$past(host_byte_i[b])}}));
   end
endmodule

bind vga_plane_wr_path vga_plane_wr_path_chk #(.PLANES(PLANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/vga_plane_wr_path_test.sv
module vga_plane_wr_path_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid_i = 1'b0;
   logic [7:0]  host_byte_i = '0;
   logic [1:0]  wmode_i = '0;
   logic [2:0]  rot_cnt_i = '0;
   logic [3:0]  sr_val_i = '0;
   logic [3:0]  sr_en_i = '0;
   logic [7:0]  bmask_i = '0;
   logic [3:0]  plane_en_i = '0;
   logic        rd_load_i = 1'b0;
   logic [31:0] rd_dword_i = '0;
   logic [31:0] wdata_o;
   logic [3:0]  wbe_o;
   logic        wvalid_o;

   int checks = 0;
   int errors = 0;
   logic [31:0] m_lat = '0;
   logic [31:0] m_data = '0;
   logic [3:0]  m_be = '0;
   logic        m_valid = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vga_plane_wr_path uut (.*);

   function automatic logic [7:0] rotr(logic [7:0] x, logic [2:0] r);
      logic [15:0] d;
      d = {x, x} >> r;
      return d[7:0];
   endfunction

   function automatic logic [31:0] ref_word(logic [7:0] h, logic [1:0] md, logic [2:0] r,
                                            logic [3:0] sv, logic [3:0] se, logic [7:0] bm,
                                            logic [31:0] lat);
      logic [7:0]  hr, mk, pl;
      logic [31:0] res;
      hr = rotr(h, r);
      if (md == 2'd1) return lat;
      mk = (md == 2'd3) ? (hr & bm) : bm;
      for (int b = 0; b < 4; b++) begin
         case (md)
            2'd0:    pl = se[b] ? {8{sv[b]}} : hr;
            2'd2:    pl = {8{h[b]}};
            default: pl = {8{sv[b]}};
         endcase
         for (int n = 0; n < 8; n++)
            res[b*8+n] = mk[n] ? pl[n] : lat[b*8+n];
      end
      return res;
   endfunction

   task automatic check(string tag);
      checks++;
      if (wdata_o !== m_data || wbe_o !== m_be || wvalid_o !== m_valid) begin
         errors++;
         $display("FAIL %s: got data=%h be=%h v=%b, expected data=%h be=%h v=%b",
                  tag, wdata_o, wbe_o, wvalid_o, m_data, m_be, m_valid);
      end
   endtask

   task automatic op(logic wv, logic [7:0] h, logic [1:0] md, logic [2:0] r,
                     logic [3:0] sv, logic [3:0] se, logic [7:0] bm, logic [3:0] pe,
                     logic ld, logic [31:0] dw, string tag);
      wr_valid_i = wv; host_byte_i = h; wmode_i = md; rot_cnt_i = r;
      sr_val_i = sv; sr_en_i = se; bmask_i = bm; plane_en_i = pe;
      rd_load_i = ld; rd_dword_i = dw;
      m_valid = wv;
      if (wv) begin
         m_data = ref_word(h, md, r, sv, se, bm, m_lat);
         m_be   = pe;
      end
      if (ld) m_lat = dw;
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0417));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 reset outputs");
      op(1, 8'hFF, 2'd1, 3'd5, 4'hF, 4'hF, 8'hFF, 4'hF, 0, 32'h0, "R10 latch zero after reset");
      op(0, 8'h00, 2'd0, 3'd0, 4'h0, 4'h0, 8'h00, 4'h0, 1, 32'hA5C3_0F96, "R9 idle hold during load");
      op(1, 8'h3C, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 4'h5, 0, 32'h0, "R2 host data to planes");
      op(1, 8'h3C, 2'd0, 3'd0, 4'h1, 4'h5, 8'hFF, 4'hA, 0, 32'h0, "R2 set/reset on enabled planes");
      op(1, 8'h81, 2'd0, 3'd7, 4'h0, 4'h0, 8'hFF, 4'hF, 0, 32'h0, "R1 rotate by seven");
      op(1, 8'h96, 2'd0, 3'd3, 4'h0, 4'h0, 8'hFF, 4'hF, 0, 32'h0, "R1 rotate by three");
      op(1, 8'h5A, 2'd1, 3'd2, 4'h3, 4'hC, 8'h00, 4'h6, 0, 32'h0, "R3 latch copy ignores host");
      op(1, 8'hFA, 2'd2, 3'd4, 4'h0, 4'h0, 8'hFF, 4'hF, 0, 32'h0, "R4 color expand unrotated");
      op(1, 8'hFA, 2'd2, 3'd0, 4'h0, 4'h0, 8'h0F, 4'hF, 0, 32'h0, "R6 partial mask merge");
      op(1, 8'h77, 2'd0, 3'd1, 4'h9, 4'h3, 8'h00, 4'h1, 0, 32'h0, "R6 zero mask keeps latch");
      op(1, 8'hF0, 2'd3, 3'd4, 4'h6, 4'h0, 8'h3C, 4'hF, 0, 32'h0, "R5 fill with host-derived mask");
      op(1, 8'h00, 2'd1, 3'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 1, 32'h1234_5678, "R7 same-cycle load uses old latch");
      op(1, 8'h00, 2'd1, 3'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 0, 32'h0, "R7 new latch visible next");
      op(0, 8'hEE, 2'd0, 3'd0, 4'hF, 4'hF, 8'hFF, 4'h0, 0, 32'h0, "R9 no write holds output");
      op(1, 8'h01, 2'd3, 3'd0, 4'hF, 4'h0, 8'hFF, 4'h9, 0, 32'h0, "R8 byte enables pass through");
      for (int k = 0; k < 400; k++) begin
         op(($urandom % 4) != 0, 8'($urandom), 2'($urandom), 3'($urandom),
            4'($urandom), 4'($urandom), 8'($urandom), 4'($urandom),
            ($urandom % 3) == 0, $urandom, "R6 random mix");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule